// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with Hi/Lo Result Pair

This block performs 32×32 integer multiplication and division, signed or unsigned, over a number of clock cycles, and leaves the outcome in a pair of result registers named Hi and Lo. A caller raises `start` for one cycle together with an operation code and two operands. The unit then raises `busy`, runs one datapath step per cycle, and on its last step writes both result registers at once. The caller reads the results from the `hi` and `lo` outputs. These outputs hold their value until the next operation completes.

Multiplication is done by shift-and-add and division by restoring shift-and-subtract. Both run on the same pair of working registers. Signed operations are done on operand magnitudes, and the signs are corrected at the end. The unit does not detect hazards and raises no exceptions.

Top module: `muldiv_unit`

## Requirements
- R1: Operation code 0 (signed multiply) treats both operands as two's complement and places the 64-bit product with its upper half in `hi` and its lower half in `lo`.
- R2: Operation code 1 (unsigned multiply) treats both operands as unsigned and places the 64-bit product in `hi` (upper half) and `lo` (lower half).
- R3: Operation code 3 (unsigned divide) places the unsigned quotient in `lo` and the unsigned remainder in `hi`.
- R4: Operation code 2 (signed divide) truncates the quotient toward zero and gives the remainder the sign of the dividend. The quotient goes to `lo` and the remainder to `hi`. For the most negative dividend divided by -1, the result is quotient 0x80000000 and remainder 0.
- R5: A `start` that is sampled while idle makes `busy` high for exactly W consecutive cycles, beginning in the cycle after the start. The new results appear on `hi`/`lo` in the same cycle that `busy` returns low.
- R6: `hi` and `lo` do not change while an operation is in progress, and they do not change while the unit is idle.
- R7: A `start` that is sampled while `busy` is high is ignored. The running operation finishes at its original time and delivers its own result.
- R8: A divide with a zero divisor still completes after W busy cycles with `busy` falling. The contents of `hi`/`lo` in that case are not specified.
- R9: After a synchronous reset, `busy` is low and `hi` and `lo` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin an operation |
| op | input | 2 | 0 signed mul, 1 unsigned mul, 2 signed div, 3 unsigned div |
| opa | input | W | Multiplicand or dividend |
| opb | input | W | Multiplier or divisor |
| busy | output | 1 | High while an operation is iterating |
| hi | output | W | Hi result register (product upper half / remainder) |
| lo | output | W | Lo result register (product lower half / quotient) |

## Verification
On every cycle, the assertions check that an accepted start raises `busy`. They check that each busy run lasts exactly W cycles, which also catches a restart caused by a start issued mid-operation. They check that `hi`/`lo` never move unless `busy` falls, and that reset clears the outputs. Numerical correctness cannot be stated as a property. That includes the sign handling of quotients and remainders, the most-negative-by-minus-one case, and products of extreme operands. These are shown only by the bench's directed and random operations, which are compared against the language's own arithmetic on 64-bit extended values.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [1:0] {
    OP_MUL_S = 2'd0,
    OP_MUL_U = 2'd1,
    OP_DIV_S = 2'd2,
    OP_DIV_U = 2'd3
  } md_op_e;
endpackage

// File: rtl/muldiv_prep.sv
// Operand conditioning: decode, magnitudes and result sign flags.
module muldiv_prep import muldiv_pkg::*; #(
  parameter int W = 32
) (
  input  md_op_e       op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         is_div,
  output logic [W-1:0] mag_a,
  output logic [W-1:0] mag_b,
  output logic         neg_main,
  output logic         neg_rem
);
  logic sgn, sa, sb;

  always_comb begin
    sgn      = (op == OP_MUL_S) || (op == OP_DIV_S);
    is_div   = (op == OP_DIV_S) || (op == OP_DIV_U);
    sa       = sgn & a[W-1];
    sb       = sgn & b[W-1];
    mag_a    = sa ? (~a + 1'b1) : a;
    mag_b    = sb ? (~b + 1'b1) : b;
    neg_main = sa ^ sb;
    neg_rem  = is_div & sa;
  end
endmodule

// File: rtl/muldiv_step.sv
// One iteration of shift-add multiply or restoring shift-subtract divide.
module muldiv_step #(
  parameter int W = 32
) (
  input  logic         is_div,
  input  logic [W-1:0] acc_hi,
  input  logic [W-1:0] acc_lo,
  input  logic [W-1:0] opnd,
  output logic [W-1:0] nxt_hi,
  output logic [W-1:0] nxt_lo
);
  logic [W:0] add_sum;
  logic [W:0] shl;
  logic [W:0] diff;

  always_comb begin
    add_sum = {1'b0, acc_hi} + (acc_lo[0] ? {1'b0, opnd} : '0);
    shl     = {acc_hi, acc_lo[W-1]};
    diff    = shl - {1'b0, opnd};
    if (!is_div) begin
      {nxt_hi, nxt_lo} = {add_sum, acc_lo[W-1:1]};
    end else if (!diff[W]) begin
      nxt_hi = diff[W-1:0];
      nxt_lo = {acc_lo[W-2:0], 1'b1};
    end else begin
      nxt_hi = shl[W-1:0];
      nxt_lo = {acc_lo[W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/muldiv_fix.sv
// Final sign correction of the magnitude result.
module muldiv_fix #(
  parameter int W = 32
) (
  input  logic         is_div,
  input  logic         neg_main,
  input  logic         neg_rem,
  input  logic [W-1:0] raw_hi,
  input  logic [W-1:0] raw_lo,
  output logic [W-1:0] res_hi,
  output logic [W-1:0] res_lo
);
  logic [2*W-1:0] prod;

  always_comb begin
    prod = {raw_hi, raw_lo};
    if (neg_main) prod = ~prod + 1'b1;
    if (is_div) begin
      res_lo = neg_main ? (~raw_lo + 1'b1) : raw_lo;
      res_hi = neg_rem  ? (~raw_hi + 1'b1) : raw_hi;
    end else begin
      {res_hi, res_lo} = prod;
    end
  end
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit import muldiv_pkg::*; #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [1:0]   op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic         busy,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic         p_div, p_negm, p_negr;
  logic [W-1:0] p_ma, p_mb;
  logic [W-1:0] s_hi, s_lo, f_hi, f_lo;

  logic          busy_q, div_q, negm_q, negr_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  wh_q, wl_q, mb_q, hi_q, lo_q;

  muldiv_prep #(.W(W)) u_prep (
    .op(md_op_e'(op)), .a(opa), .b(opb), .is_div(p_div),
    .mag_a(p_ma), .mag_b(p_mb), .neg_main(p_negm), .neg_rem(p_negr)
  );

  muldiv_step #(.W(W)) u_step (
    .is_div(div_q), .acc_hi(wh_q), .acc_lo(wl_q), .opnd(mb_q),
    .nxt_hi(s_hi), .nxt_lo(s_lo)
  );

  muldiv_fix #(.W(W)) u_fix (
    .is_div(div_q), .neg_main(negm_q), .neg_rem(negr_q),
    .raw_hi(s_hi), .raw_lo(s_lo), .res_hi(f_hi), .res_lo(f_lo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      div_q  <= 1'b0;
      negm_q <= 1'b0;
      negr_q <= 1'b0;
      wh_q   <= '0;
      wl_q   <= '0;
      mb_q   <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        div_q  <= p_div;
        negm_q <= p_negm;
        negr_q <= p_negr;
        wh_q   <= '0;
        wl_q   <= p_ma;
        mb_q   <= p_mb;
      end
    end else begin
      wh_q  <= s_hi;
      wl_q  <= s_lo;
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) begin
        busy_q <= 1'b0;
        hi_q   <= f_hi;
        lo_q   <= f_lo;
      end
    end
  end

  assign busy = busy_q;
  assign hi   = hi_q;
  assign lo   = lo_q;
endmodule

// File: rtl/muldiv_chk.sv
module muldiv_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         busy,
  input logic [W-1:0] hi,
  input logic [W-1:0] lo
);
  localparam int RW = $clog2(W + 1) + 1;
  logic [RW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst)       run <= '0;
    else if (busy) run <= run + 1'b1;
    else           run <= '0;
  end

  p_start_busy_r5: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  // R7 and R8: a mid-run start or a zero divisor must not stretch the run
  p_busy_len_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (run == RW'(W)));

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (busy == $past(busy)) |-> ($stable(hi) && $stable(lo)));

  p_no_overrun_r7: assert property (@(posedge clk) disable iff (rst)
    busy |-> (run <= RW'(W)));

  p_reset_r9: assert property (@(posedge clk)
    rst |=> (!busy && hi == '0 && lo == '0));
endmodule

bind muldiv_unit muldiv_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .hi(hi), .lo(lo)
);

// File: tb/tb_muldiv_unit.sv
`timescale 1ns/1ps
module tb_muldiv_unit;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [1:0]   op = 2'd0;
  logic [W-1:0] opa = '0, opb = '0;
  logic         busy;
  logic [W-1:0] hi, lo;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  muldiv_unit #(.W(W)) dut (
    .clk(clk), .rst(rst), .start(start), .op(op), .opa(opa), .opb(opb),
    .busy(busy), .hi(hi), .lo(lo)
  );

  function automatic logic [63:0] expect_res(input logic [1:0] o,
                                             input logic [31:0] a,
                                             input logic [31:0] b);
    logic signed [63:0] sa, sb, q, r;
    logic [63:0] ua, ub, p;
    sa = {{32{a[31]}}, a};
    sb = {{32{b[31]}}, b};
    ua = {32'd0, a};
    ub = {32'd0, b};
    case (o)
      2'd0: p = 64'(sa * sb);
      2'd1: p = ua * ub;
      2'd2: begin
        q = sa / sb; r = sa % sb;
        p = {r[31:0], q[31:0]};
      end
      default: p = {32'(ua % ub), 32'(ua / ub)};
    endcase
    return p;
  endfunction

  function automatic string req_of(input logic [1:0] o);
    case (o)
      2'd0: return "R1";
      2'd1: return "R2";
      2'd2: return "R4";
      default: return "R3";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Runs one operation; optional mid-run start with other operands (R7).
  task automatic run_op(input logic [1:0] o, input logic [31:0] a,
                        input logic [31:0] b, input bit skip_val,
                        input bit poke);
    logic [63:0] e, prev;
    int cnt;
    e = expect_res(o, a, b);
    @(negedge clk);
    op = o; opa = a; opb = b; start = 1'b1;
    prev = {hi, lo};
    @(negedge clk);
    start = 1'b0;
    cnt = 0;
    while (busy && cnt < W + 4) begin
      cnt++;
      if (cnt == 1 || cnt == W / 2)
        check({hi, lo} == prev, "R6", "hi/lo moved while busy", {hi, lo}, prev);
      if (poke && cnt == 5) begin
        op = ~o; opa = ~a; opb = b ^ 32'h5; start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
    end
    check(cnt == W, poke ? "R7" : (skip_val ? "R8" : "R5"), "busy length",
          64'(cnt), 64'(W));
    if (!skip_val)
      check({hi, lo} == e, poke ? "R7" : req_of(o), "result", {hi, lo}, e);
  endtask

  initial begin
    logic [63:0] held;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(!busy && hi == '0 && lo == '0, "R9", "reset state",
          {31'd0, busy, hi}, 64'd0);
    rst = 1'b0;
    @(negedge clk);

    // directed corners
    run_op(2'd0, 32'hFFFF_FFFF, 32'h0000_0003, 0, 0);   // R1 -1*3
    run_op(2'd0, 32'h8000_0000, 32'h8000_0000, 0, 0);   // R1 min*min
    run_op(2'd0, 32'h8000_0000, 32'h7FFF_FFFF, 0, 0);   // R1
    run_op(2'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0);   // R2
    run_op(2'd1, 32'h0001_0000, 32'h0001_0000, 0, 0);   // R2
    run_op(2'd3, 32'hFFFF_FFFF, 32'h0000_0007, 0, 0);   // R3
    run_op(2'd3, 32'h0000_0005, 32'h0000_0009, 0, 0);   // R3 quotient 0
    run_op(2'd2, 32'hFFFF_FFF9, 32'h0000_0002, 0, 0);   // R4 -7/2
    run_op(2'd2, 32'h0000_0007, 32'hFFFF_FFFE, 0, 0);   // R4 7/-2
    run_op(2'd2, 32'hFFFF_FFF9, 32'hFFFF_FFFE, 0, 0);   // R4 -7/-2
    run_op(2'd2, 32'h8000_0000, 32'hFFFF_FFFF, 0, 0);   // R4 min/-1
    run_op(2'd2, 32'd100, 32'd0, 1, 0);                 // R8 zero divisor
    run_op(2'd3, 32'd100, 32'd0, 1, 0);                 // R8
    run_op(2'd1, 32'd123456, 32'd789, 0, 1);            // R7 ignored start
    run_op(2'd2, 32'hFFFF_0000, 32'd77, 0, 1);          // R7

    // idle hold: R6
    held = {hi, lo};
    @(negedge clk);
    opa = 32'hDEAD_BEEF;
    repeat (4) @(negedge clk);
    check({hi, lo} == held && !busy, "R6", "idle hold", {hi, lo}, held);

    // random mix
    for (int i = 0; i < 80; i++) begin
      logic [1:0] ro;
      logic [31:0] ra, rb;
      ro = 2'($urandom_range(0, 3));
      ra = $urandom;
      rb = $urandom;
      if (i % 4 == 1) rb = rb >> $urandom_range(0, 31);
      if (rb == 0) rb = 32'd1;
      run_op(ro, ra, rb, 0, 0);
    end

    // reset mid-run: R9
    @(negedge clk);
    op = 2'd1; opa = 32'd9; opb = 32'd9; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(!busy && hi == '0 && lo == '0, "R9", "reset mid-run",
          {31'd0, busy, hi}, 64'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule